// File: doc/BRIEF.md
# Translation Lookup with Zone-Qualified Access Checking

This block is the lookup stage of a small, fully associative address translation cache. Each request carries an effective address, a process tag, an access kind and a privilege flag. The block searches every entry at once. One clock later it returns either a translated address or a single outcome code. The possible outcomes are a fetch-side miss, a data-side miss, a fetch protection fault, a data protection fault, or a silent suppression of the operation.

Each entry carries execute, write and guarded permission bits and a zone index. The zone index selects a two-bit field from a protection word that is supplied as an input. The value of that field can widen or narrow the entry's own permissions, and it does so differently in user and supervisor state. Software loads the entries through a simple write port. Software also handles refills, replacement and fault vectoring.

Top module: `tlb_zone_lookup`

## Requirements
- R1: A request hits only on an entry that is valid and whose stored page tag equals the upper address bits (above the 12-bit page offset) and whose process tag equals the request's. A permitted hit returns code 0 with the address formed from the entry's real page number and the request's page offset.
- R2: With translation enabled and no entry hitting, an instruction fetch (op 0) returns code 1 and any other operation except cache touch returns code 2.
- R3: When several entries hit, the lowest-numbered entry supplies the result.
- R4: In user state a fetch faults (code 3) when the selected zone field is 00, or when the execute bit is 0 and the field is not 11.
- R5: In supervisor state a fetch faults (code 3) when the execute bit is 0 and the field is 00 or 01.
- R6: A fetch from an entry with the guarded bit set faults (code 3) in both privilege states.
- R7: Ops 2 (store), 3 (cache-block invalidate, zero or congruence-class invalidate) and 4 (allocate) are write-class. In supervisor state they fault when the write bit is 0 and the field is 00 or 01. In user state every data op faults when the field is 00, and write-class ops also fault when the write bit is 0 and the field is not 11. A data fault is code 4. Loads (op 1, and the unused ops 6 and 7) ignore the guarded and write bits.
- R8: An allocate (op 4) that meets a fault condition returns code 5 (suppressed) and never returns code 4. A missing allocate still returns code 2.
- R9: A cache touch (op 5) returns code 5 on a miss or on a fault condition, and never returns code 2 or code 4.
- R10: When translation is disabled for the side that an access uses (fetch side for op 0, data side otherwise), the result is code 0 and the request address is passed through unchanged.
- R11: The result appears on the clock edge after the request, and res_valid follows req_valid with one cycle of delay. For every code other than 0, res_addr equals the request address.
- R12: Reset clears every entry's valid bit. A write sets all fields of the indexed entry at the clock edge and is seen by requests from the next cycle onward. The zone field for index k sits at bits 2k+1:2k of the protection word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 3 | Entry index to write |
| wr_valid | input | 1 | Valid bit written |
| wr_tag | input | 20 | Virtual page tag written |
| wr_pid | input | 8 | Process tag written |
| wr_rpn | input | 20 | Real page number written |
| wr_zone | input | 4 | Zone index written |
| wr_exec | input | 1 | Execute permission written |
| wr_write | input | 1 | Write permission written |
| wr_guard | input | 1 | Guarded bit written |
| zone_prot | input | 32 | Sixteen two-bit zone fields |
| xlat_fetch_en | input | 1 | Translation enable, fetch side |
| xlat_data_en | input | 1 | Translation enable, data side |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 32 | Effective address |
| req_pid | input | 8 | Request process tag |
| req_op | input | 3 | Access kind (0 fetch, 1 load, 2 store, 3 invalidate/zero, 4 allocate, 5 touch) |
| req_super | input | 1 | 1 for supervisor state |
| res_valid | output | 1 | Result strobe |
| res_addr | output | 32 | Translated or passed-through address |
| res_code | output | 3 | Outcome (0 ok, 1 fetch miss, 2 data miss, 3 fetch fault, 4 data fault, 5 suppressed) |

## Verification
The central stimulus is a full sweep over privilege state, all four zone values, and the execute, write and guarded bits, with each of the six access kinds issued against every combination. This sweep separates the user and supervisor override rules and shows which operations are suppressed rather than faulted. Separate patterns mismatch only the process tag, only the page tag, or only the valid bit, so that a partial match cannot pass as a hit. A pair of duplicate entries shows the lowest-index winner, and disabling one translation side at a time shows that pass-through applies to that side alone.

// File: rtl/tlb_zone_lookup.sv
module tlb_zone_lookup #(
  parameter int ENTRIES = 8,
  parameter int EA_W    = 32,
  parameter int PG_W    = 12,
  parameter int PID_W   = 8,
  parameter int ZONES   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ZI_W   = $clog2(ZONES),
  localparam int VPN_W  = EA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] wr_tag,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_rpn,
  input  logic [ZI_W-1:0]  wr_zone,
  input  logic             wr_exec,
  input  logic             wr_write,
  input  logic             wr_guard,
  input  logic [2*ZONES-1:0] zone_prot,
  input  logic             xlat_fetch_en,
  input  logic             xlat_data_en,
  input  logic             req_valid,
  input  logic [EA_W-1:0]  req_ea,
  input  logic [PID_W-1:0] req_pid,
  input  logic [2:0]       req_op,
  input  logic             req_super,
  output logic             res_valid,
  output logic [EA_W-1:0]  res_addr,
  output logic [2:0]       res_code
);

  localparam logic [2:0] C_OK = 3'd0, C_IMISS = 3'd1, C_DMISS = 3'd2,
                         C_IFLT = 3'd3, C_DFLT = 3'd4, C_NOP = 3'd5;

  logic [ENTRIES-1:0] e_valid;
  logic [VPN_W-1:0]   e_tag  [ENTRIES];
  logic [PID_W-1:0]   e_pid  [ENTRIES];
  logic [VPN_W-1:0]   e_rpn  [ENTRIES];
  logic [ZI_W-1:0]    e_zone [ENTRIES];
  logic [ENTRIES-1:0] e_exec, e_write, e_guard;

  always_ff @(posedge clk) begin
    if (!rst_n) e_valid <= '0;
    else if (wr_en) begin
      e_valid[wr_idx] <= wr_valid;
      e_tag[wr_idx]   <= wr_tag;
      e_pid[wr_idx]   <= wr_pid;
      e_rpn[wr_idx]   <= wr_rpn;
      e_zone[wr_idx]  <= wr_zone;
      e_exec[wr_idx]  <= wr_exec;
      e_write[wr_idx] <= wr_write;
      e_guard[wr_idx] <= wr_guard;
    end
  end

  logic [ENTRIES-1:0] hit_vec;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = e_valid[i] && (e_tag[i] == req_ea[EA_W-1:PG_W]) && (e_pid[i] == req_pid);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = IDX_W'(i);
  end

  wire       hit      = |hit_vec;
  wire [1:0] zf       = zone_prot[{e_zone[sel], 1'b0} +: 2];
  wire       ex       = e_exec[sel];
  wire       wp       = e_write[sel];
  wire       gd       = e_guard[sel];
  wire       is_fetch = (req_op == 3'd0);
  wire       is_alloc = (req_op == 3'd4);
  wire       is_touch = (req_op == 3'd5);
  wire       wr_class = (req_op == 3'd2) || (req_op == 3'd3) || is_alloc;
  wire       xl_on    = is_fetch ? xlat_fetch_en : xlat_data_en;

  wire f_fetch = gd || (req_super ? (!ex && !zf[1])
                                  : ((zf == 2'b00) || (!ex && zf != 2'b11)));
  wire f_data  = req_super ? (wr_class && !wp && !zf[1])
                           : ((zf == 2'b00) || (wr_class && !wp && zf != 2'b11));

  logic [2:0] code_d;
  always_comb begin
    if (!xl_on)        code_d = C_OK;
    else if (!hit)     code_d = is_fetch ? C_IMISS : (is_touch ? C_NOP : C_DMISS);
    else if (is_fetch) code_d = f_fetch ? C_IFLT : C_OK;
    else if (f_data)   code_d = (is_alloc || is_touch) ? C_NOP : C_DFLT;
    else               code_d = C_OK;
  end

  wire [EA_W-1:0] addr_d = (xl_on && code_d == C_OK) ? {e_rpn[sel], req_ea[PG_W-1:0]} : req_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_code  <= C_OK;
      res_addr  <= '0;
    end else begin
      res_valid <= req_valid;
      res_code  <= code_d;
      res_addr  <= addr_d;
    end
  end

endmodule

module tlb_zone_lookup_chk #(
  parameter int EA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlat_fetch_en,
  input logic            req_valid,
  input logic [EA_W-1:0] req_ea,
  input logic [2:0]      req_op,
  input logic            res_valid,
  input logic [EA_W-1:0] res_addr,
  input logic [2:0]      res_code
);

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  p_fault_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_code == 3'd0 || res_addr == $past(req_ea)));
  p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0 && !xlat_fetch_en) |=> (res_code == 3'd0 && res_addr == $past(req_ea)));
  p_fetch_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 3'd0) |=> (res_code != 3'd1 && res_code != 3'd3));
  p_alloc_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |=> res_code != 3'd4);
  p_touch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd5) |=> (res_code != 3'd2 && res_code != 3'd4));
  p_code_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code <= 3'd5);

endmodule

bind tlb_zone_lookup tlb_zone_lookup_chk #(.EA_W(EA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_fetch_en(xlat_fetch_en),
  .req_valid(req_valid), .req_ea(req_ea), .req_op(req_op),
  .res_valid(res_valid), .res_addr(res_addr), .res_code(res_code)
);

// File: tb/tb_tlb_zone_lookup.sv
module tb_tlb_zone_lookup;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, wr_exec = 0, wr_write = 0, wr_guard = 0;
  logic [2:0] wr_idx = 0;
  logic [19:0] wr_tag = 0, wr_rpn = 0;
  logic [7:0] wr_pid = 0;
  logic [3:0] wr_zone = 0;
  logic [31:0] zone_prot = '1;
  logic xlat_fetch_en = 1, xlat_data_en = 1;
  logic req_valid = 0, req_super = 0;
  logic [31:0] req_ea = 0;
  logic [7:0] req_pid = 0;
  logic [2:0] req_op = 0;
  logic res_valid;
  logic [31:0] res_addr;
  logic [2:0] res_code;

  tlb_zone_lookup dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] q_addr[$];
  logic [2:0]  q_code[$];
  string       q_req[$];

  logic        m_valid[8];
  logic [19:0] m_tag[8], m_rpn[8];
  logic [7:0]  m_pid[8];
  logic [3:0]  m_zone[8];
  logic        m_ex[8], m_wr[8], m_g[8];

  function automatic void model(input logic [31:0] ea, input logic [7:0] pid, input logic [2:0] op,
                                input logic sup, output logic [31:0] a, output logic [2:0] c);
    int h;
    logic fetch, xl, bad, wcls;
    logic [1:0] z;
    h = -1;
    for (int i = 0; i < 8; i++)
      if (h < 0 && m_valid[i] && m_tag[i] == ea[31:12] && m_pid[i] == pid) h = i;
    fetch = (op == 0);
    xl = fetch ? xlat_fetch_en : xlat_data_en;
    a = ea;
    c = 0;
    if (!xl) return;
    if (h < 0) begin
      c = fetch ? 3'd1 : (op == 5 ? 3'd5 : 3'd2);
      return;
    end
    z = 2'((zone_prot >> (2 * m_zone[h])) & 32'd3);
    wcls = (op == 2 || op == 3 || op == 4);
    bad = 0;
    if (fetch) begin
      if (m_g[h]) bad = 1;
      if (!sup && z == 0) bad = 1;
      if (!sup && !m_ex[h] && z != 3) bad = 1;
      if (sup && !m_ex[h] && z != 3 && z != 2) bad = 1;
      c = bad ? 3'd3 : 3'd0;
    end else begin
      if (!sup && z == 0) bad = 1;
      if (!sup && wcls && !m_wr[h] && z != 3) bad = 1;
      if (sup && wcls && !m_wr[h] && z < 2) bad = 1;
      if (bad) c = (op == 4 || op == 5) ? 3'd5 : 3'd4;
    end
    if (c == 0) a = {m_rpn[h], ea[11:0]};
  endfunction

  task automatic wr_entry(input int idx, input logic v, input logic [19:0] tag, input logic [7:0] pid,
                          input logic [19:0] rpn, input logic [3:0] zn, input logic ex, input logic w, input logic g);
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_idx = 3'(idx); wr_valid = v; wr_tag = tag; wr_pid = pid;
    wr_rpn = rpn; wr_zone = zn; wr_exec = ex; wr_write = w; wr_guard = g;
    m_valid[idx] = v; m_tag[idx] = tag; m_pid[idx] = pid; m_rpn[idx] = rpn;
    m_zone[idx] = zn; m_ex[idx] = ex; m_wr[idx] = w; m_g[idx] = g;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic issue(input logic [31:0] ea, input logic [7:0] pid, input logic [2:0] op,
                       input logic sup, input string rq);
    logic [31:0] a;
    logic [2:0] c;
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_pid = pid; req_op = op; req_super = sup;
    model(ea, pid, op, sup, a, c);
    q_addr.push_back(a); q_code.push_back(c); q_req.push_back(rq);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && res_valid) begin
      checks++;
      if (q_code.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected result code=%0d expected none", res_code);
      end else begin
        logic [31:0] ea_x;
        logic [2:0] ec_x;
        string rq;
        ea_x = q_addr.pop_front(); ec_x = q_code.pop_front(); rq = q_req.pop_front();
        if (res_code !== ec_x || res_addr !== ea_x) begin
          errors++;
          $display("FAIL %s code=%0d addr=%h expected code=%0d addr=%h", rq, res_code, res_addr, ec_x, ea_x);
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin errors++; $display("FAIL R12 res_valid=%b expected 0", res_valid); end

    // R12 and R2: reset leaves every entry invalid
    issue(32'h1234_5678, 8'd7, 3'd0, 0, "R12 R2 fetch miss after reset");
    issue(32'h1234_5678, 8'd7, 3'd1, 0, "R2 load miss");
    issue(32'h1234_5678, 8'd7, 3'd3, 1, "R2 invalidate miss");
    issue(32'h1234_5678, 8'd7, 3'd4, 0, "R8 alloc miss");
    issue(32'h1234_5678, 8'd7, 3'd5, 0, "R9 touch miss");
    idle();

    // R10: each translation side is disabled on its own
    @(negedge clk); xlat_fetch_en = 0;
    issue(32'hDEAD_BEEF, 8'd1, 3'd0, 0, "R10 fetch pass-through");
    issue(32'hDEAD_BEEF, 8'd1, 3'd1, 0, "R10 data side still translated");
    idle();
    @(negedge clk); xlat_fetch_en = 1; xlat_data_en = 0;
    issue(32'hCAFE_0001, 8'd1, 3'd2, 0, "R10 store pass-through");
    issue(32'hCAFE_0001, 8'd1, 3'd0, 0, "R10 fetch side still translated");
    idle();
    @(negedge clk); xlat_data_en = 1;

    // R1: a hit needs the valid bit, the page tag and the process tag to match
    wr_entry(1, 1, 20'h12345, 8'd7, 20'hABCDE, 4'd5, 1, 1, 0);
    issue(32'h1234_5678, 8'd7, 3'd0, 0, "R1 fetch hit");
    issue(32'h1234_5FFF, 8'd7, 3'd2, 1, "R1 store hit");
    issue(32'h1234_5678, 8'd8, 3'd0, 0, "R1 pid mismatch");
    issue(32'h1234_6678, 8'd7, 3'd1, 0, "R1 tag mismatch");
    wr_entry(1, 0, 20'h12345, 8'd7, 20'hABCDE, 4'd5, 1, 1, 0);
    issue(32'h1234_5678, 8'd7, 3'd0, 0, "R12 invalidated entry misses");
    idle();

    // R3: the lowest index wins among duplicates
    wr_entry(6, 1, 20'h55555, 8'd2, 20'h66666, 4'd0, 1, 1, 0);
    wr_entry(2, 1, 20'h55555, 8'd2, 20'h22222, 4'd0, 1, 1, 0);
    issue(32'h5555_5123, 8'd2, 3'd1, 0, "R3 lowest index wins");
    wr_entry(2, 0, 20'h55555, 8'd2, 20'h22222, 4'd0, 1, 1, 0);
    issue(32'h5555_5123, 8'd2, 3'd1, 0, "R3 next entry after invalidate");
    idle();

    // R4 R5 R6 R7 R8 R9: sweep of privilege, zone value and permission bits
    for (int sup = 0; sup < 2; sup++)
      for (int z = 0; z < 4; z++)
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          zone_prot = '1;
          zone_prot[19:18] = 2'(z);
          wr_entry(0, 1, 20'h00777, 8'd3, 20'h0F0F0, 4'd9, b[0], b[1], b[2]);
          issue(32'h0077_7ABC, 8'd3, 3'd0, sup[0], "R4 R5 R6 fetch");
          issue(32'h0077_7ABC, 8'd3, 3'd1, sup[0], "R7 load");
          issue(32'h0077_7ABC, 8'd3, 3'd2, sup[0], "R7 store");
          issue(32'h0077_7ABC, 8'd3, 3'd3, sup[0], "R7 invalidate");
          issue(32'h0077_7ABC, 8'd3, 3'd4, sup[0], "R8 alloc");
          issue(32'h0077_7ABC, 8'd3, 3'd5, sup[0], "R9 touch");
          idle();
        end

    repeat (4) @(negedge clk);
    checks++;
    if (q_code.size() != 0) begin
      errors++;
      $display("FAIL R11 pending=%0d expected 0", q_code.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule